// File: doc/BRIEF.md
# Flash Interrupt and Status Register Controller

This block is the register front end of a flash controller. It holds the command word, two system configuration words, a controller status word with error flags and an interrupt status word. Software reaches it over a simple synchronous 16-bit bus with a registered read path. A separate command engine receives accepted commands and reports completion back through a one-cycle done strobe.

Software issues a command by writing the command register. The write is refused while the master interrupt flag is pending. Recognised codes are passed to the engine. An unrecognised code raises a command error and the master interrupt flag at once. Software acknowledges an interrupt by writing a mask that is ANDed into the interrupt word. If the master flag is gone after that AND, every error flag in the status word is also cleared. The interrupt pin's polarity comes from a configuration bit. The ready pin takes the value of another configuration bit whenever that word is written. The asynchronous reset loads cold values and a synchronous warm-reset request loads warm values.

Top module: `flash_evt_regs`

## Requirements
- R1: After the asynchronous reset, config-1 reads 0x40C0, config-2 reads 0, status reads 0, interrupt reads 0x8080, the command register reads 0, `irq` is 1, `rdy` is 1 and `cmd_valid` is 0.
- R2: A one-cycle `warm_rst` pulse loads the same values as R1, except that the interrupt word becomes 0x8010; it overrides any access in the same cycle.
- R3: A write to the interrupt register (offset 4) replaces its value with the old value AND the written data, in the cycle after the write.
- R4: If interrupt bit 15 is 0 after that AND, status bits 13:10 (error flags) are cleared; if bit 15 stays 1, they are kept.
- R5: A write to the command register (offset 0) while interrupt bit 15 is 1 changes neither the command register nor `cmd_valid`.
- R6: An accepted write of a recognised code (0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0xF0, 0xF3, 0x65) stores the code, drives it on `cmd_code` and raises `cmd_valid` for exactly the one cycle after the write.
- R7: An accepted write of any other code stores it, sets status bit 10 and interrupt bit 15, and does not raise `cmd_valid`.
- R8: A `done_valid` cycle sets interrupt bit 15, ORs `done_type[3:0]` into interrupt bits 7:4 (reset, erase, program, load) and ORs `done_err[3:0]` into status bits 13:10 (command, erase, program, load).
- R9: `irq` equals interrupt bit 15 when config-1 bit 6 is 1 (active high), and its inverse when config-1 bit 6 is 0.
- R10: A write to config-1 (offset 1) sets `rdy` to bit 7 of the written data.
- R11: Config-1 reads back with bits 4:0 forced to 0. Config-2 (offset 2) reads back all 16 bits as written.
- R12: Read data appears on `bus_rdata` one clock after the address. Writes to status (offset 3) are ignored. Offsets 5 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the cold values |
| warm_rst | input | 1 | Synchronous warm-reset request |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| done_valid | input | 1 | Completion strobe from the command engine |
| done_type | input | 4 | One-hot completion kind: reset, erase, program, load |
| done_err | input | 4 | Error flags posted with completion: command, erase, program, load |
| cmd_valid | output | 1 | One-cycle pulse for an accepted recognised command |
| cmd_code | output | 16 | Current command register |
| irq | output | 1 | Interrupt output, polarity from config-1 bit 6 |
| rdy | output | 1 | Ready output |

## Verification
On every cycle, the assertions check the AND-mask update of the interrupt word and the error clearing tied to the master flag. They also check that gated command writes are dropped, that a posted completion sets its flags, the warm-reset values, the ready pin and the masked low bits of config-1. The bench's scenarios are needed for the rest: which codes count as recognised, that an unknown code is never forwarded, the interrupt pin under both polarity settings, and the exact cold-reset values seen through the bus. They also cover the read-only status word and the unmapped offsets.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;

  localparam int unsigned DATA_W     = 16;
  localparam int unsigned EVT_N      = 4;
  localparam int unsigned INT_MASTER = 15;
  localparam int unsigned DONE_LSB   = 4;
  localparam int unsigned ERR_LSB    = 10;
  localparam int unsigned CFG1_POL   = 6;
  localparam int unsigned CFG1_RDY   = 7;

  localparam logic [DATA_W-1:0] CFG1_RST  = 16'h40C0;
  localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
  localparam logic [DATA_W-1:0] CFG1_RDM  = 16'hFFE0;
  localparam logic [DATA_W-1:0] ERR_MASK  = {{(DATA_W-ERR_LSB-EVT_N){1'b0}}, {EVT_N{1'b1}}, {ERR_LSB{1'b0}}};

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CMD, SEL_CFG1, SEL_CFG2, SEL_STAT, SEL_INT
  } reg_sel_e;

  function automatic logic known_cmd(input logic [DATA_W-1:0] code);
    case (code)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h00F0,
      16'h00F3, 16'h0065: known_cmd = 1'b1;
      default:            known_cmd = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flash_evt_regmux.sv
module flash_evt_regmux
  import flash_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_CMD  = 0,
  parameter int unsigned OFS_CFG1 = 1,
  parameter int unsigned OFS_CFG2 = 2,
  parameter int unsigned OFS_STAT = 3,
  parameter int unsigned OFS_INT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cmd_q,
  input  logic [DATA_W-1:0] cfg1_q,
  input  logic [DATA_W-1:0] cfg2_q,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] int_q,
  output reg_sel_e          sel,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sel = SEL_NONE;
    if      (int'(addr) == OFS_CMD)  sel = SEL_CMD;
    else if (int'(addr) == OFS_CFG1) sel = SEL_CFG1;
    else if (int'(addr) == OFS_CFG2) sel = SEL_CFG2;
    else if (int'(addr) == OFS_STAT) sel = SEL_STAT;
    else if (int'(addr) == OFS_INT)  sel = SEL_INT;
  end

  always_comb begin
    case (sel)
      SEL_CMD:  rdata_d = cmd_q;
      SEL_CFG1: rdata_d = cfg1_q & CFG1_RDM;
      SEL_CFG2: rdata_d = cfg2_q;
      SEL_STAT: rdata_d = stat_q;
      SEL_INT:  rdata_d = int_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // R11: the low five bits of config-1 never reach the bus
  a_r11_cfg1_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CFG1) |=> (rdata_q[4:0] == 5'd0));

endmodule

// File: rtl/flash_evt_cmd.sv
module flash_evt_cmd
  import flash_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              int_busy,
  output logic [DATA_W-1:0] cmd_q,
  output logic              cmd_valid,
  output logic              unknown
);

  logic              take;
  logic              cmd_en;
  logic [DATA_W-1:0] cmd_d;
  logic              valid_d;

  always_comb begin
    take    = wr_en && !int_busy && !warm_rst;
    unknown = take && !known_cmd(wdata);
    cmd_en  = take || warm_rst;
    cmd_d   = warm_rst ? '0 : wdata;
    valid_d = take && known_cmd(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      cmd_valid <= valid_d;
    end
  end

  // R5: a write while the master flag is pending leaves no trace
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int_busy && !warm_rst) |=> (!cmd_valid && $stable(cmd_q)));

  // R6: a forwarded command is always a recognised code
  a_r6_known_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> known_cmd(cmd_q));

endmodule

// File: rtl/flash_evt_intstat.sv
module flash_evt_intstat
  import flash_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_int,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_valid,
  input  logic [EVT_N-1:0]  done_type,
  input  logic [EVT_N-1:0]  done_err,
  input  logic              unknown,
  output logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] stat_q
);

  logic [DATA_W-1:0] int_masked;
  logic [DATA_W-1:0] post_int;
  logic [DATA_W-1:0] post_err;
  logic [DATA_W-1:0] int_d;
  logic [DATA_W-1:0] stat_d;
  logic              ack_clr;
  logic              upd_en;

  always_comb begin
    int_masked = wr_int ? (int_q & wdata) : int_q;
    ack_clr    = wr_int && !int_masked[INT_MASTER];

    post_int = '0;
    post_int[INT_MASTER] = done_valid || unknown;
    post_int[DONE_LSB +: EVT_N] = done_valid ? done_type : '0;

    post_err = '0;
    post_err[ERR_LSB +: EVT_N] = done_valid ? done_err : '0;
    post_err[ERR_LSB] = post_err[ERR_LSB] || unknown;

    int_d  = int_masked | post_int;
    stat_d = (ack_clr ? (stat_q & ~ERR_MASK) : stat_q) | post_err;
    if (warm_rst) begin
      int_d  = INT_WARM;
      stat_d = '0;
    end
    upd_en = wr_int || done_valid || unknown || warm_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (upd_en) begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end

  // R3: acknowledge is a pure AND mask when nothing else is posted
  a_r3_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !done_valid && !unknown && !warm_rst)
      |=> (int_q == ($past(int_q) & $past(wdata))));

  // R4: dropping the master flag wipes the error flags
  a_r4_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !(int_q[INT_MASTER] && wdata[INT_MASTER]) && !done_valid && !unknown && !warm_rst)
      |=> ((stat_q & ERR_MASK) == '0));

  // R8: a completion post raises the master flag and its done bit
  a_r8_post: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !warm_rst)
      |=> (int_q[INT_MASTER] && ((int_q[DONE_LSB +: EVT_N] & $past(done_type)) == $past(done_type))));

  // R2: warm reset values
  a_r2_warm: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> ((int_q == INT_WARM) && (stat_q == '0)));

endmodule

// File: rtl/flash_evt_cfg.sv
module flash_evt_cfg
  import flash_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_cfg1,
  input  logic              wr_cfg2,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg1_q,
  output logic [DATA_W-1:0] cfg2_q,
  output logic              rdy_q
);

  logic              c1_en, c2_en;
  logic [DATA_W-1:0] c1_d, c2_d;
  logic              rdy_d;

  always_comb begin
    c1_en = wr_cfg1 || warm_rst;
    c2_en = wr_cfg2 || warm_rst;
    c1_d  = warm_rst ? CFG1_RST : wdata;
    c2_d  = warm_rst ? '0 : wdata;
    rdy_d = warm_rst ? 1'b1 : wdata[CFG1_RDY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else begin
      if (c1_en) cfg1_q <= c1_d;
      if (c2_en) cfg2_q <= c2_d;
      if (c1_en) rdy_q  <= rdy_d;
    end
  end

  // R10: ready follows bit 7 of each config-1 write
  a_r10_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg1 && !warm_rst) |=> (rdy_q == $past(wdata[CFG1_RDY])));

endmodule

// File: rtl/flash_evt_regs.sv
module flash_evt_regs
  import flash_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFS_CMD  = 0,
  parameter int unsigned OFS_CFG1 = 1,
  parameter int unsigned OFS_CFG2 = 2,
  parameter int unsigned OFS_STAT = 3,
  parameter int unsigned OFS_INT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              done_valid,
  input  logic [3:0]        done_type,
  input  logic [3:0]        done_err,
  output logic              cmd_valid,
  output logic [15:0]       cmd_code,
  output logic              irq,
  output logic              rdy
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] cmd_q, cfg1_q, cfg2_q, stat_q, int_q;
  logic              unknown;
  logic              wr_cmd, wr_cfg1, wr_cfg2, wr_int;

  always_comb begin
    wr_cmd  = bus_we && (sel == SEL_CMD);
    wr_cfg1 = bus_we && (sel == SEL_CFG1);
    wr_cfg2 = bus_we && (sel == SEL_CFG2);
    wr_int  = bus_we && (sel == SEL_INT);
  end

  flash_evt_regmux #(
    .ADDR_W(ADDR_W), .OFS_CMD(OFS_CMD), .OFS_CFG1(OFS_CFG1),
    .OFS_CFG2(OFS_CFG2), .OFS_STAT(OFS_STAT), .OFS_INT(OFS_INT)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .cmd_q(cmd_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q),
    .stat_q(stat_q), .int_q(int_q),
    .sel(sel), .rdata_q(bus_rdata)
  );

  flash_evt_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .wr_en(wr_cmd), .wdata(bus_wdata), .int_busy(int_q[INT_MASTER]),
    .cmd_q(cmd_q), .cmd_valid(cmd_valid), .unknown(unknown)
  );

  flash_evt_intstat u_int (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .wr_int(wr_int), .wdata(bus_wdata),
    .done_valid(done_valid), .done_type(done_type), .done_err(done_err),
    .unknown(unknown), .int_q(int_q), .stat_q(stat_q)
  );

  flash_evt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .wr_cfg1(wr_cfg1), .wr_cfg2(wr_cfg2), .wdata(bus_wdata),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .rdy_q(rdy)
  );

  assign cmd_code = cmd_q;
  assign irq      = int_q[INT_MASTER] ^ ~cfg1_q[CFG1_POL];

  // R7: an unknown code raises the command error and master flag
  a_r7_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (unknown && !warm_rst) |=> (stat_q[ERR_LSB] && int_q[INT_MASTER] && !cmd_valid));

endmodule

// File: tb/flash_evt_regs_bench.sv
`timescale 1ns/1ps
module flash_evt_regs_bench;

  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [3:0] A_CMD = 4'h0, A_C1 = 4'h1, A_C2 = 4'h2, A_ST = 4'h3, A_IN = 4'h4;
  localparam int NV = 29;

  // {op, addr, wdata, expected, requirement number}
  localparam logic [41:0] VECS [0:NV-1] = '{
    {OP_RD, A_IN,  16'h0000, 16'h8080, 4'd1},  // R1
    {OP_RD, A_C1,  16'h0000, 16'h40C0, 4'd1},  // R1
    {OP_RD, A_C2,  16'h0000, 16'h0000, 4'd1},  // R1
    {OP_RD, A_ST,  16'h0000, 16'h0000, 4'd1},  // R1
    {OP_RD, A_CMD, 16'h0000, 16'h0000, 4'd1},  // R1
    {OP_WR, A_CMD, 16'h0094, 16'h0000, 4'd5},  // R5 blocked write
    {OP_RD, A_CMD, 16'h0000, 16'h0000, 4'd5},  // R5
    {OP_RD, A_IN,  16'h0000, 16'h8080, 4'd5},  // R5
    {OP_WR, A_IN,  16'h7FFF, 16'h0000, 4'd3},  // R3
    {OP_RD, A_IN,  16'h0000, 16'h0080, 4'd3},  // R3
    {OP_WR, A_CMD, 16'h0094, 16'h0000, 4'd6},  // R6
    {OP_RD, A_CMD, 16'h0000, 16'h0094, 4'd6},  // R6
    {OP_WR, A_CMD, 16'h0055, 16'h0000, 4'd7},  // R7 unknown
    {OP_RD, A_ST,  16'h0000, 16'h0400, 4'd7},  // R7
    {OP_RD, A_IN,  16'h0000, 16'h8080, 4'd7},  // R7
    {OP_RD, A_CMD, 16'h0000, 16'h0055, 4'd7},  // R7
    {OP_WR, A_IN,  16'hFFFF, 16'h0000, 4'd4},  // R4 master kept
    {OP_RD, A_ST,  16'h0000, 16'h0400, 4'd4},  // R4
    {OP_WR, A_IN,  16'h0000, 16'h0000, 4'd4},  // R4 master dropped
    {OP_RD, A_ST,  16'h0000, 16'h0000, 4'd4},  // R4
    {OP_RD, A_IN,  16'h0000, 16'h0000, 4'd3},  // R3
    {OP_WR, A_C1,  16'hFFFF, 16'h0000, 4'd11}, // R11
    {OP_RD, A_C1,  16'h0000, 16'hFFE0, 4'd11}, // R11
    {OP_WR, A_C2,  16'h1234, 16'h0000, 4'd11}, // R11
    {OP_RD, A_C2,  16'h0000, 16'h1234, 4'd11}, // R11
    {OP_WR, A_ST,  16'hFFFF, 16'h0000, 4'd12}, // R12 read-only
    {OP_RD, A_ST,  16'h0000, 16'h0000, 4'd12}, // R12
    {OP_RD, 4'hF,  16'h0000, 16'h0000, 4'd12}, // R12 unmapped
    {OP_WR, A_C1,  16'h40C0, 16'h0000, 4'd11}  // R11 restore
  };

  logic        clk = 1'b0;
  logic        rst_n, warm_rst, bus_we, done_valid;
  logic [3:0]  bus_addr, done_type, done_err;
  logic [15:0] bus_wdata, bus_rdata, cmd_code;
  logic        cmd_valid, irq, rdy;
  int checks = 0;
  int fails  = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  flash_evt_regs u_flash_evt_regs (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_valid(done_valid), .done_type(done_type), .done_err(done_err),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq(irq), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; warm_rst = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    done_valid = 1'b0; done_type = '0; done_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'd1);
    chk("R1 rdy", {15'd0, rdy}, 16'd1);
    chk("R1 cmd_valid", {15'd0, cmd_valid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][41:40] == OP_WR) begin
        bus_write(VECS[i][39:36], VECS[i][35:20]);
      end else begin
        bus_read(VECS[i][39:36], rv);
        chk($sformatf("R%0d vector %0d", VECS[i][3:0], i), rv, VECS[i][19:4]);
      end
    end

    // R6: recognised code is forwarded for one cycle
    bus_write(A_CMD, 16'h0080);
    chk("R6 cmd_valid high", {15'd0, cmd_valid}, 16'd1);
    chk("R6 cmd_code", cmd_code, 16'h0080);
    @(negedge clk);
    chk("R6 cmd_valid one cycle", {15'd0, cmd_valid}, 16'd0);

    // R8: completion post from the engine
    @(negedge clk);
    done_valid = 1'b1; done_type = 4'b0100; done_err = 4'b0100;
    @(negedge clk);
    done_valid = 1'b0; done_type = '0; done_err = '0;
    bus_read(A_IN, rv); chk("R8 interrupt word", rv, 16'h8040);
    bus_read(A_ST, rv); chk("R8 status word", rv, 16'h1000);
    chk("R9 active-high pending", {15'd0, irq}, 16'd1);

    // R9 / R10: active-low polarity, ready from bit 7
    bus_write(A_C1, 16'h0080);
    chk("R9 active-low pending", {15'd0, irq}, 16'd0);
    chk("R10 rdy set", {15'd0, rdy}, 16'd1);
    bus_write(A_IN, 16'h0000);
    chk("R9 active-low idle", {15'd0, irq}, 16'd1);
    bus_read(A_ST, rv); chk("R4 cleared after post", rv, 16'h0000);
    bus_write(A_C1, 16'h0000);
    chk("R10 rdy clear", {15'd0, rdy}, 16'd0);

    // R7: unknown code never forwarded
    bus_write(A_CMD, 16'h00AB);
    chk("R7 no cmd_valid", {15'd0, cmd_valid}, 16'd0);
    bus_read(A_IN, rv); chk("R7 master flag", rv, 16'h8000);

    // R2: warm reset
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    bus_read(A_IN, rv);  chk("R2 interrupt word", rv, 16'h8010);
    bus_read(A_ST, rv);  chk("R2 status word", rv, 16'h0000);
    bus_read(A_C1, rv);  chk("R2 config-1", rv, 16'h40C0);
    bus_read(A_C2, rv);  chk("R2 config-2", rv, 16'h0000);
    bus_read(A_CMD, rv); chk("R2 command", rv, 16'h0000);
    chk("R2 rdy", {15'd0, rdy}, 16'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule